// File: doc/BRIEF.md
# Scan ring selective save/restore sequencer

This block drives a scan-rotate engine so that a few chosen bit fields of a long circular scan ring survive a power cycle of the domain that holds the ring. Before power-down it runs in save mode. It selects the scan region, loads a 64-bit check pattern into the engine's scan window, and walks the ring in nine rotate steps. After each of the first eight steps it captures the masked bits of the window into one of eight internal 64-bit slots. After the domain has been re-initialised, it runs in restore mode. The walk is the same, but each of the first eight steps merges the stored bits back into the window and leaves the unmasked bits as they are.

The ninth rotate brings the ring back to its start. The check pattern must then read back unchanged. If it does not, the block raises a check error and keeps the observed window word for diagnosis. Each rotate has a completion deadline that software can program. When a rotate misses it, the sequence stops with a separate timeout error. A run takes place only when the memory-preserving reboot input is set and the chip revision is below the workaround limit. In every other case a start completes at once and the engine is not accessed.

Top module: `ring_keep_seq`

## Requirements
- R1: If `reboot_keep` is 0 or `chip_rev` >= 0x20, a `start` produces `done` in the following cycle. `busy` stays 0, and `sel_we`, `win_we` and `rot_go` never assert.
- R2: An enabled run first writes the select word 0x0800_0000_0000_0830 (only bits 59, 11, 5 and 4 set). The last select write of every run, including an aborted run, carries zero.
- R3: The first window write of a run carries 0xA5A5A5A5A5A5A5A5 and comes before any rotate command.
- R4: A run without errors issues exactly nine rotates. Rotate k carries P[k]-P[k-1] in bits 63:32 and zero in bits 31:0, where P = 0, 5039, 5100, 5664, 5725, 5973, 6034, 6282, 6343, 17871.
- R5: After a rotate the block polls `stat_word` and issues no further command until bit 8 reads 1. It ignores all other status bits.
- R6: In save mode (`mode_restore`=0), after rotate k (k = 1..8) the block stores window AND M[k] in slot k-1. M[k] is 0xE000000000000000 for odd k and 0xC1E061FFED5F0000 for even k. The only window write of a save run is the check pattern.
- R7: In restore mode, after rotate k (k = 1..8) the block writes (window AND NOT M[k]) OR slot k-1 into the window.
- R8: After rotate 9 the window is compared with the check pattern. On a mismatch `err_check` rises and `bad_window` holds the observed word. On a match no error is set.
- R9: If status bit 8 stays 0 for more than `tmo_limit` polled cycles, the run aborts. The block writes the zero select word, sets `err_timeout` and ends with `done`.
- R10: `busy` is 1 from the cycle after an enabled `start` until `done`. `done` is a one-cycle pulse with `busy` 0. The error outputs are cleared by the next `start` and are never both set.
- R11: The slots keep their contents across restore, disabled and aborted runs, and change only in a later save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| mode_restore | input | 1 | 0 = save, 1 = restore; latched at start |
| reboot_keep | input | 1 | Memory-preserving reboot in progress |
| chip_rev | input | 8 | Chip revision; workaround below the limit |
| tmo_limit | input | 16 | Rotate completion deadline in polled cycles |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_check | output | 1 | Check pattern did not return intact |
| err_timeout | output | 1 | A rotate missed its deadline |
| bad_window | output | 64 | Window word observed on a check failure |
| sel_we | output | 1 | Region/type select write strobe |
| sel_word | output | 64 | Region/type select data |
| rot_go | output | 1 | Rotate command strobe |
| rot_word | output | 64 | Rotate command word, length in bits 63:32 |
| win_we | output | 1 | Scan window write strobe |
| win_wdata | output | 64 | Scan window write data |
| win_rdata | input | 64 | Current scan window contents |
| stat_word | input | 64 | Engine status, bit 8 = rotate complete |

## Verification
The bench models the engine as a 17871-bit ring. Random ring contents are saved, the ring is reseeded, and every restore write is compared with a merge worked out from the windows the model exposed. A wrong mask, slot index or merge direction therefore shows as a bit difference. Rotate latencies are swept over several values, and stray status bits are always held high, which separates true completion polling from early progress. A final-bit corruption, a hung engine, a revision exactly at the limit and a cleared reboot flag each exercise a different exit path. Restores after aborted and disabled runs show that the slot contents are kept.

// File: rtl/ring_keep_pkg.sv
package ring_keep_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned NSTEP  = 9;
  localparam logic [WORD_W-1:0] CHECK_PAT = 64'hA5A5_A5A5_A5A5_A5A5;
  localparam logic [WORD_W-1:0] MASK_ODD  = 64'hE000_0000_0000_0000;
  localparam logic [WORD_W-1:0] MASK_EVEN = 64'hC1E0_61FF_ED5F_0000;

  typedef enum logic [2:0] {
    S_IDLE, S_SEL, S_PAT, S_ROT, S_WAIT, S_ACT, S_CLR, S_FIN
  } seq_state_t;

  // cumulative ring position reached after step k
  function automatic logic [31:0] ring_pos(input logic [3:0] k);
    case (k)
      4'd0:    ring_pos = 32'd0;
      4'd1:    ring_pos = 32'd5039;
      4'd2:    ring_pos = 32'd5100;
      4'd3:    ring_pos = 32'd5664;
      4'd4:    ring_pos = 32'd5725;
      4'd5:    ring_pos = 32'd5973;
      4'd6:    ring_pos = 32'd6034;
      4'd7:    ring_pos = 32'd6282;
      4'd8:    ring_pos = 32'd6343;
      default: ring_pos = 32'd17871;
    endcase
  endfunction

  function automatic logic [31:0] step_len(input logic [3:0] k);
    step_len = ring_pos(k) - ring_pos(k - 4'd1);
  endfunction

  function automatic logic [WORD_W-1:0] step_mask(input logic [3:0] k);
    if (k == 4'd0 || k >= 4'd9) step_mask = '0;
    else if (k[0])              step_mask = MASK_ODD;
    else                        step_mask = MASK_EVEN;
  endfunction

  function automatic logic [WORD_W-1:0] select_word();
    logic [WORD_W-1:0] w;
    w = '0;
    w[4]  = 1'b1;
    w[5]  = 1'b1;
    w[11] = 1'b1;
    w[59] = 1'b1;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] merge_bits(input logic [WORD_W-1:0] win,
                                                   input logic [WORD_W-1:0] mask,
                                                   input logic [WORD_W-1:0] keep);
    merge_bits = (win & ~mask) | keep;
  endfunction
endpackage

// File: rtl/ring_keep_slots.sv
module ring_keep_slots #(
  parameter int unsigned NSLOT = 8,
  parameter int unsigned W     = 64,
  localparam int unsigned AW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] slot_q [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slot_q[i] <= '0;
      else if (we && (waddr == AW'(i)))             slot_q[i] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];
endmodule

// File: rtl/ring_keep_timer.sv
module ring_keep_timer #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt_q;

  assign expired = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear)          cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ring_keep_seq.sv
module ring_keep_seq
  import ring_keep_pkg::*;
#(
  parameter int unsigned NSLOT     = 8,
  parameter int unsigned TMO_W     = 16,
  parameter int unsigned REV_W     = 8,
  parameter logic [7:0]  REV_LIMIT = 8'h20,
  parameter int unsigned DONE_BIT  = 8,
  localparam int unsigned SW       = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_restore,
  input  logic              reboot_keep,
  input  logic [REV_W-1:0]  chip_rev,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              busy,
  output logic              done,
  output logic              err_check,
  output logic              err_timeout,
  output logic [WORD_W-1:0] bad_window,
  output logic              sel_we,
  output logic [WORD_W-1:0] sel_word,
  output logic              rot_go,
  output logic [WORD_W-1:0] rot_word,
  output logic              win_we,
  output logic [WORD_W-1:0] win_wdata,
  input  logic [WORD_W-1:0] win_rdata,
  input  logic [WORD_W-1:0] stat_word
);
  seq_state_t        st_q;
  logic [3:0]        step_q;
  logic              mode_q;
  logic              run_en;
  logic              rot_ok;
  logic              tmo_hit;
  logic              last_step;
  logic              act_edit;
  logic              slot_we;
  logic [SW-1:0]     slot_idx;
  logic [WORD_W-1:0] cur_mask;
  logic [WORD_W-1:0] slot_rd;

  assign run_en    = reboot_keep && (chip_rev < REV_W'(REV_LIMIT));
  assign rot_ok    = stat_word[DONE_BIT];
  assign last_step = (step_q == 4'(NSTEP));
  assign cur_mask  = step_mask(step_q);
  assign slot_idx  = SW'(step_q - 4'd1);
  assign act_edit  = (st_q == S_ACT) && !last_step;
  assign slot_we   = act_edit && !mode_q;

  ring_keep_slots #(.NSLOT(NSLOT), .W(WORD_W)) u_slots (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (slot_we),
    .waddr(slot_idx),
    .wdata(win_rdata & cur_mask),
    .raddr(slot_idx),
    .rdata(slot_rd)
  );

  ring_keep_timer #(.TMO_W(TMO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (st_q == S_ROT),
    .run    ((st_q == S_WAIT) && !rot_ok),
    .limit  (tmo_limit),
    .expired(tmo_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      step_q      <= 4'd0;
      mode_q      <= 1'b0;
      err_check   <= 1'b0;
      err_timeout <= 1'b0;
      bad_window  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          err_check   <= 1'b0;
          err_timeout <= 1'b0;
          mode_q      <= mode_restore;
          step_q      <= 4'd1;
          st_q        <= run_en ? S_SEL : S_FIN;
        end
        S_SEL:  st_q <= S_PAT;
        S_PAT:  st_q <= S_ROT;
        S_ROT:  st_q <= S_WAIT;
        S_WAIT: begin
          if (rot_ok) st_q <= S_ACT;
          else if (tmo_hit) begin
            err_timeout <= 1'b1;
            st_q        <= S_CLR;
          end
        end
        S_ACT: begin
          if (last_step) begin
            if (win_rdata != CHECK_PAT) begin
              err_check  <= 1'b1;
              bad_window <= win_rdata;
            end
            st_q <= S_CLR;
          end else begin
            step_q <= step_q + 4'd1;
            st_q   <= S_ROT;
          end
        end
        S_CLR:   st_q <= S_FIN;
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = !(st_q inside {S_IDLE, S_FIN});
    done      = (st_q == S_FIN);
    sel_we    = (st_q == S_SEL) || (st_q == S_CLR);
    sel_word  = (st_q == S_SEL) ? select_word() : '0;
    rot_go    = (st_q == S_ROT);
    rot_word  = {step_len(step_q), 32'h0};
    win_we    = (st_q == S_PAT) || (act_edit && mode_q);
    win_wdata = (st_q == S_PAT) ? CHECK_PAT : merge_bits(win_rdata, cur_mask, slot_rd);
  end
endmodule

// File: rtl/ring_keep_chk.sv
module ring_keep_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic run_en,
  input logic busy,
  input logic done,
  input logic err_check,
  input logic err_timeout,
  input logic sel_we,
  input logic win_we,
  input logic rot_go,
  input logic slot_we,
  input logic act_edit,
  input logic mode_q
);
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                  // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && run_en) |=> busy);                    // R10
  AST_ACCESS_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we || win_we || rot_go) |-> busy);                           // R1
  AST_ROT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rot_go |=> !rot_go);                                              // R5
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_check && err_timeout));                                     // R10
  AST_SAVE_NO_EDIT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_edit && !mode_q) |-> (slot_we && !win_we));                  // R6
  AST_RESTORE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (act_edit && mode_q) |-> (win_we && !slot_we));                   // R7
  AST_TMO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> sel_we);                                   // R9
endmodule

bind ring_keep_seq ring_keep_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .run_en     (run_en),
  .busy       (busy),
  .done       (done),
  .err_check  (err_check),
  .err_timeout(err_timeout),
  .sel_we     (sel_we),
  .win_we     (win_we),
  .rot_go     (rot_go),
  .slot_we    (slot_we),
  .act_edit   (act_edit),
  .mode_q     (mode_q)
);

// File: tb/tb_ring_keep_seq.sv
module tb_ring_keep_seq;
  localparam int RL = 17871;

  logic clk = 0, rst_n = 0;
  logic start = 0, mode_restore = 0, reboot_keep = 0;
  logic [7:0]  chip_rev = 8'h10;
  logic [15:0] tmo_limit = 16'd200;
  logic busy, done, err_check, err_timeout, sel_we, rot_go, win_we;
  logic [63:0] bad_window, sel_word, rot_word, win_wdata, win_rdata, stat_word;

  always #2.5 clk = ~clk;

  ring_keep_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_restore(mode_restore),
    .reboot_keep(reboot_keep), .chip_rev(chip_rev), .tmo_limit(tmo_limit),
    .busy(busy), .done(done), .err_check(err_check), .err_timeout(err_timeout),
    .bad_window(bad_window), .sel_we(sel_we), .sel_word(sel_word),
    .rot_go(rot_go), .rot_word(rot_word), .win_we(win_we), .win_wdata(win_wdata),
    .win_rdata(win_rdata), .stat_word(stat_word)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // engine model
  logic [RL-1:0] ring;
  logic stat8 = 1, pend = 0, hang = 0, flip = 0, reseed = 0;
  int delay = 2, cnt = 0, rk = 0, plen = 0, sel_cnt = 0, acc_cnt = 0, wr_cnt = 0;
  logic [63:0] obs [1:9];
  logic [63:0] kept [1:8];
  logic [63:0] last_sel;
  int pos [10] = '{0, 5039, 5100, 5664, 5725, 5973, 6034, 6282, 6343, 17871};

  function automatic logic [63:0] mask_of(input int k);
    return (k % 2 == 1) ? 64'hE000_0000_0000_0000 : 64'hC1E0_61FF_ED5F_0000;
  endfunction

  assign win_rdata = ring[63:0];
  assign stat_word = (64'(stat8) << 8) | 64'h0000_0000_0000_0280;

  always @(posedge clk) begin
    logic [RL-1:0] nr;
    logic [RL+63:0] seed;
    if (reseed) begin
      for (int i = 0; i < (RL + 64) / 32; i++) seed[i*32 +: 32] = $urandom;
      ring <= seed[RL-1:0];
      pend <= 0; stat8 <= 1; rk <= 0;
    end else begin
      if (sel_we || win_we || rot_go) acc_cnt <= acc_cnt + 1;
      if (sel_we) begin
        if (sel_cnt == 0)
          chk(sel_word == ((64'd1 << 59) | (64'd1 << 11) | (64'd1 << 5) | (64'd1 << 4)),
              "R2 first select word", sel_word, 64'h0800_0000_0000_0830);
        last_sel <= sel_word;
        sel_cnt  <= sel_cnt + 1;
        if (sel_cnt == 0) rk <= 0;
      end
      if (win_we) begin
        wr_cnt <= wr_cnt + 1;
        if (rk == 0)
          chk(win_wdata == 64'hA5A5_A5A5_A5A5_A5A5, "R3 pattern before rotate", win_wdata, 64'hA5A5_A5A5_A5A5_A5A5);
        else if (rk >= 1 && rk <= 8)
          chk(win_wdata == ((obs[rk] & ~mask_of(rk)) | (kept[rk] & mask_of(rk))),
              "R7 restore merge of R6 slot", win_wdata, (obs[rk] & ~mask_of(rk)) | (kept[rk] & mask_of(rk)));
        ring[63:0] <= win_wdata;
      end
      if (rot_go) begin
        chk(!pend, "R5 rotate issued before completion", 64'(pend), 64'd0);
        chk(rot_word == {32'(pos[rk+1] - pos[rk]), 32'h0}, "R4 rotate length", rot_word,
            {32'(pos[rk+1] - pos[rk]), 32'h0});
        plen <= pos[rk+1] - pos[rk];
        rk <= rk + 1; pend <= 1; stat8 <= 0; cnt <= delay;
      end else if (pend && !hang) begin
        if (cnt == 0) begin
          nr = (ring >> plen) | (ring << (RL - plen));
          if (flip && rk == 9) nr[0] = ~nr[0];
          ring <= nr; obs[rk] <= nr[63:0]; pend <= 0; stat8 <= 1;
        end else cnt <= cnt - 1;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic new_ring();
    @(negedge clk); reseed = 1; @(negedge clk); reseed = 0;
  endtask

  // run one sequence; returns busy seen in first cycle and cycles to done
  task automatic run(input logic rst_mode, output logic b1, output int lat);
    sel_cnt = 0; acc_cnt = 0; wr_cnt = 0;
    @(negedge clk); mode_restore = rst_mode; start = 1;
    @(negedge clk); start = 0; b1 = busy; lat = 1;
    while (!done) begin @(negedge clk); lat++; end
    chk(!busy, "R10 busy low at done", 64'(busy), 64'd0);
    @(negedge clk);
    chk(!done, "R10 done is one pulse", 64'(done), 64'd0);
  endtask

  initial begin
    logic b1; int lat;
    ring = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err_check && !err_timeout && !sel_we && !rot_go && !win_we,
        "R10 reset state", {59'd0, busy, done, err_check, err_timeout, rot_go}, 64'd0);
    rst_n = 1;
    new_ring();

    // R1: gated off
    reboot_keep = 0; chip_rev = 8'h10;
    run(1'b0, b1, lat);
    chk(lat == 1 && !b1, "R1 reboot flag low", 64'(lat), 64'd1);
    chk(acc_cnt == 0, "R1 no access flag low", 64'(acc_cnt), 64'd0);
    reboot_keep = 1; chip_rev = 8'h20;
    run(1'b0, b1, lat);
    chk(lat == 1 && acc_cnt == 0, "R1 revision at limit", 64'(acc_cnt), 64'd0);
    chip_rev = 8'h1F;

    // sweep of latencies: save then restore
    foreach (pos[d]) if (d < 3) begin
      delay = d * 3;
      new_ring();
      run(1'b0, b1, lat);
      chk(b1, "R10 busy after start", 64'(b1), 64'd1);
      chk(wr_cnt == 1, "R6 save writes only the pattern", 64'(wr_cnt), 64'd1);
      chk(rk == 9, "R4 nine rotates", 64'(rk), 64'd9);
      chk(last_sel == 64'd0, "R2 select cleared", last_sel, 64'd0);
      chk(!err_check && !err_timeout, "R8 save round trip clean", {62'd0, err_check, err_timeout}, 64'd0);
      for (int k = 1; k <= 8; k++) kept[k] = obs[k];
      new_ring();
      run(1'b1, b1, lat);
      chk(wr_cnt == 9, "R7 eight merges plus pattern", 64'(wr_cnt), 64'd9);
      chk(!err_check && !err_timeout, "R8 restore round trip clean", {62'd0, err_check, err_timeout}, 64'd0);
    end

    // R8: corrupted return
    new_ring(); flip = 1;
    run(1'b1, b1, lat);
    flip = 0;
    chk(err_check && !err_timeout, "R8 check error raised", {62'd0, err_check, err_timeout}, 64'd2);
    chk(bad_window == 64'hA5A5_A5A5_A5A5_A5A4, "R8 bad window latched", bad_window, 64'hA5A5_A5A5_A5A5_A5A4);

    // R9: hung engine in save mode
    hang = 1; tmo_limit = 16'd5;
    run(1'b0, b1, lat);
    chk(err_timeout && !err_check, "R9 timeout error", {62'd0, err_check, err_timeout}, 64'd1);
    chk(last_sel == 64'd0, "R9 select cleared on abort", last_sel, 64'd0);
    chk(rk == 1, "R9 no rotate after abort", 64'(rk), 64'd1);
    hang = 0; tmo_limit = 16'd200;

    // R11: slots survive aborted and disabled runs
    reboot_keep = 0;
    run(1'b1, b1, lat);
    chk(!err_timeout, "R10 errors cleared by start", 64'(err_timeout), 64'd0);
    reboot_keep = 1; delay = 1;
    new_ring();
    run(1'b1, b1, lat);
    chk(wr_cnt == 9 && !err_check, "R11 restore after aborted save", 64'(wr_cnt), 64'd9);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule